// File: doc/BRIEF.md
# Read-Mark Tracking and Value Validation

This block holds the data array of a small transactional first-level data cache. For every line it also keeps a vector of read marks, with one bit for each data word. While a transaction is open, each load sets the mark of the word it touches. A load that finds its line stale does not wait. It gets the held copy at once, as on a hit, and the block raises a refill request for that line in the same cycle.

When the refill response comes back, the block compares only the marked words of the held copy with the incoming words. Any difference in a marked word means another agent changed a value the transaction actually consumed. In that case the block pulses its abort output and drops all marks. The response data always replaces the held line, whether or not the comparison passed. Two cases therefore never cost an abort: a write by another core to a neighbouring word of the same line, and a store that rewrote the same value. Evicting a line that still carries marks also aborts, because its old value can no longer be checked. Ending the transaction, by commit or by external abort, flash-clears every mark.

Top module: `rdmark_validator`

## Requirements
- R1: After reset, abort_o is 0, refill_req_o is 0, no transaction is open and every word of every line reads as zero.
- R2: ld_data_o presents the held word at (ld_line_i, ld_word_i) combinationally in the same cycle, whatever the value of ld_stale_i.
- R3: A load with ld_stale_i=1 drives refill_req_o=1 with refill_line_o=ld_line_i in the same cycle. A load with ld_stale_i=0 drives refill_req_o=0.
- R4: A load sets the read mark of its word only while a transaction is open. A load made outside a transaction leaves no mark, so a later response that changes that word does not abort.
- R5: A response in which a marked word differs from the held word raises abort_o in the cycle after the response is accepted.
- R6: A response whose differences are all in unmarked words, or a response to a line with no marks, never raises abort_o.
- R7: A response that carries values equal to the held values in all marked words (a silent rewrite) does not raise abort_o.
- R8: On every response, the addressed line takes the response data, whether validation passes or fails.
- R9: A detected conflict closes the transaction and clears all marks. A later mismatching response therefore raises no abort until a new transaction marks words again.
- R10: txn_commit_i or txn_abort_i closes the transaction and flash-clears all marks in one cycle. A mismatch on a word read in the previous transaction does not abort the next one.
- R11: evict_valid_i for a line holding at least one mark, during a transaction, raises abort_o in the next cycle. Evicting an unmarked line does not.
- R12: abort_o is a pulse exactly one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| txn_begin_i | input | 1 | Opens a transaction |
| txn_commit_i | input | 1 | Ends the transaction after a successful commit |
| txn_abort_i | input | 1 | Ends the transaction because of an abort from elsewhere |
| ld_valid_i | input | 1 | Load request |
| ld_line_i | input | 3 | Line index of the load |
| ld_word_i | input | 4 | Word offset of the load within the line |
| ld_stale_i | input | 1 | Line is present but its permission has been lost |
| ld_data_o | output | 32 | Word returned to the load |
| refill_req_o | output | 1 | Request to fetch a fresh copy of a stale line |
| refill_line_o | output | 3 | Line index of the refill request |
| rsp_valid_i | input | 1 | Refill response valid |
| rsp_line_i | input | 3 | Line index of the response |
| rsp_data_i | input | 512 | Full line of response data |
| evict_valid_i | input | 1 | A line is leaving the array |
| evict_line_i | input | 3 | Index of the evicted line |
| abort_o | output | 1 | One-cycle conflict pulse |

## Verification
The main function is tested with a table of transactions. Each one reads one word from a stale line and then receives a response that changes the same word, a different word of that line, or no word at all. This separates a true conflict from false sharing and from a silent rewrite. Directed sequences then check the cases that depend on how marks live and die. A load made outside a transaction must leave no mark, and an earlier abort or commit must clear the marks. An eviction must abort only for a marked line. A read-back after every response shows that the refill took effect even when validation failed.

// File: rtl/rdmark_validator.sv
module rdmark_validator #(
  parameter int LINES     = 8,
  parameter int WORDS     = 16,
  parameter int WORD_BITS = 32,
  localparam int LINE_W    = $clog2(LINES),
  localparam int WORD_W    = $clog2(WORDS),
  localparam int LINE_BITS = WORDS * WORD_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 txn_begin_i,
  input  logic                 txn_commit_i,
  input  logic                 txn_abort_i,
  input  logic                 ld_valid_i,
  input  logic [LINE_W-1:0]    ld_line_i,
  input  logic [WORD_W-1:0]    ld_word_i,
  input  logic                 ld_stale_i,
  output logic [WORD_BITS-1:0] ld_data_o,
  output logic                 refill_req_o,
  output logic [LINE_W-1:0]    refill_line_o,
  input  logic                 rsp_valid_i,
  input  logic [LINE_W-1:0]    rsp_line_i,
  input  logic [LINE_BITS-1:0] rsp_data_i,
  input  logic                 evict_valid_i,
  input  logic [LINE_W-1:0]    evict_line_i,
  output logic                 abort_o
);

  logic [LINE_BITS-1:0]         data_q [LINES];
  logic [LINES-1:0][WORDS-1:0]  marks_q;
  logic                         in_txn_q;
  logic                         abort_q;
  logic [WORDS-1:0]             word_diff;
  logic                         rsp_conflict, evict_conflict, conflict, txn_end;

  assign ld_data_o     = data_q[ld_line_i][ld_word_i*WORD_BITS +: WORD_BITS];
  assign refill_req_o  = ld_valid_i & ld_stale_i;
  assign refill_line_o = ld_line_i;

  for (genvar w = 0; w < WORDS; w++) begin : g_cmp
    assign word_diff[w] = data_q[rsp_line_i][w*WORD_BITS +: WORD_BITS]
                       != rsp_data_i[w*WORD_BITS +: WORD_BITS];
  end

  assign rsp_conflict   = rsp_valid_i & |(marks_q[rsp_line_i] & word_diff);
  assign evict_conflict = evict_valid_i & |marks_q[evict_line_i];
  assign conflict       = in_txn_q & (rsp_conflict | evict_conflict);
  assign txn_end        = conflict | txn_commit_i | txn_abort_i;
  assign abort_o        = abort_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      in_txn_q <= 1'b0;
      abort_q  <= 1'b0;
      marks_q  <= '0;
    end else begin
      abort_q <= conflict;
      if (txn_end) begin
        in_txn_q <= 1'b0;
        marks_q  <= '0;
      end else begin
        if (txn_begin_i) in_txn_q <= 1'b1;
        if (ld_valid_i && in_txn_q) marks_q[ld_line_i][ld_word_i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int l = 0; l < LINES; l++) data_q[l] <= '0;
    end else if (rsp_valid_i) begin
      data_q[rsp_line_i] <= rsp_data_i;
    end
  end

endmodule

// File: rtl/rdmark_validator_chk.sv
module rdmark_validator_chk #(
  parameter int LINES = 8,
  parameter int WORDS = 16,
  localparam int LINE_W = $clog2(LINES),
  localparam int WORD_W = $clog2(WORDS)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        ld_valid_i,
  input logic                        ld_stale_i,
  input logic [LINE_W-1:0]           ld_line_i,
  input logic [WORD_W-1:0]           ld_word_i,
  input logic                        refill_req_o,
  input logic [LINE_W-1:0]           refill_line_o,
  input logic                        rsp_valid_i,
  input logic [LINE_W-1:0]           rsp_line_i,
  input logic                        evict_valid_i,
  input logic [LINE_W-1:0]           evict_line_i,
  input logic                        in_txn_q,
  input logic [LINES-1:0][WORDS-1:0] marks_q,
  input logic                        abort_o
);

  a_r12_abort_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);

  a_r5_abort_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_o) |-> $past(rsp_valid_i || evict_valid_i));

  a_r9_abort_clears_marks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (marks_q == '0 && !in_txn_q));

  a_r6_unmarked_rsp_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && !evict_valid_i && marks_q[rsp_line_i] == '0) |=> !abort_o);

  a_r11_unmarked_evict_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evict_valid_i && !rsp_valid_i && marks_q[evict_line_i] == '0) |=> !abort_o);

  a_r4_mark_outside_txn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_txn_q && marks_q == '0) |=> (marks_q == '0));

  a_r3_refill_on_stale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && ld_stale_i) |-> (refill_req_o && refill_line_o == ld_line_i));

  a_r4_word_marked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && in_txn_q && !rsp_valid_i && !evict_valid_i) |=>
      (marks_q[$past(ld_line_i)][$past(ld_word_i)] || $past(ld_valid_i && !in_txn_q)
       || marks_q == '0));

endmodule

bind rdmark_validator rdmark_validator_chk #(.LINES(LINES), .WORDS(WORDS)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ld_valid_i   (ld_valid_i),
  .ld_stale_i   (ld_stale_i),
  .ld_line_i    (ld_line_i),
  .ld_word_i    (ld_word_i),
  .refill_req_o (refill_req_o),
  .refill_line_o(refill_line_o),
  .rsp_valid_i  (rsp_valid_i),
  .rsp_line_i   (rsp_line_i),
  .evict_valid_i(evict_valid_i),
  .evict_line_i (evict_line_i),
  .in_txn_q     (in_txn_q),
  .marks_q      (marks_q),
  .abort_o      (abort_o)
);

// File: tb/rdmark_validator_tb_top.sv
`timescale 1ns/1ps
module rdmark_validator_tb_top;
  localparam int LINES = 8, WORDS = 16, WB = 32;
  localparam int LB = WORDS * WB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic txn_begin = 0, txn_commit = 0, txn_abort = 0;
  logic ld_valid = 0, ld_stale = 0;
  logic [2:0] ld_line = '0;
  logic [3:0] ld_word = '0;
  logic [WB-1:0] ld_data;
  logic refill_req;
  logic [2:0] refill_line;
  logic rsp_valid = 0;
  logic [2:0] rsp_line = '0;
  logic [LB-1:0] rsp_data = '0;
  logic evict_valid = 0;
  logic [2:0] evict_line = '0;
  logic abort;

  int runs = 0, fails = 0;
  bit done = 0;
  logic [WB-1:0] mem [LINES][WORDS];

  always #2.5 clk = ~clk;

  rdmark_validator dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .txn_begin_i(txn_begin), .txn_commit_i(txn_commit), .txn_abort_i(txn_abort),
    .ld_valid_i(ld_valid), .ld_line_i(ld_line), .ld_word_i(ld_word), .ld_stale_i(ld_stale),
    .ld_data_o(ld_data), .refill_req_o(refill_req), .refill_line_o(refill_line),
    .rsp_valid_i(rsp_valid), .rsp_line_i(rsp_line), .rsp_data_i(rsp_data),
    .evict_valid_i(evict_valid), .evict_line_i(evict_line), .abort_o(abort)
  );

  // fields: line[12:10] word[9:6] changed-word[5:1] (31 = none) expect-abort[0]
  localparam logic [12:0] VEC [8] = '{
    {3'd1, 4'd3,  5'd3,  1'b1},
    {3'd1, 4'd3,  5'd4,  1'b0},
    {3'd2, 4'd0,  5'd31, 1'b0},
    {3'd7, 4'd15, 5'd15, 1'b1},
    {3'd0, 4'd8,  5'd9,  1'b0},
    {3'd5, 4'd5,  5'd5,  1'b1},
    {3'd3, 4'd0,  5'd15, 1'b0},
    {3'd6, 4'd12, 5'd31, 1'b0}
  };

  task automatic check(bit ok, string req, logic [WB-1:0] act, logic [WB-1:0] exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_begin();  txn_begin = 1;  @(negedge clk); txn_begin = 0;  endtask
  task automatic pulse_commit(); txn_commit = 1; @(negedge clk); txn_commit = 0; endtask
  task automatic pulse_abort();  txn_abort = 1;  @(negedge clk); txn_abort = 0;  endtask

  task automatic do_load(int l, int w, bit stale, string req);
    ld_valid = 1; ld_line = 3'(l); ld_word = 4'(w); ld_stale = stale;
    #1;
    check(ld_data == mem[l][w], {req, " R2 load data"}, ld_data, mem[l][w]);
    check(refill_req == stale && (!stale || refill_line == 3'(l)),
          {req, " R3 refill request"}, {31'd0, refill_req}, {31'd0, stale});
    @(negedge clk);
    ld_valid = 0; ld_stale = 0;
  endtask

  task automatic do_rsp(int l, int chg, logic [WB-1:0] xv, bit exp_abort, string req);
    logic [WB-1:0] nw [WORDS];
    for (int w = 0; w < WORDS; w++) begin
      nw[w] = (w == chg) ? (mem[l][w] ^ xv) : mem[l][w];
      rsp_data[w*WB +: WB] = nw[w];
    end
    rsp_valid = 1; rsp_line = 3'(l);
    @(negedge clk);
    check(abort == exp_abort, {req, " abort after response"}, {31'd0, abort}, {31'd0, exp_abort});
    rsp_valid = 0;
    for (int w = 0; w < WORDS; w++) mem[l][w] = nw[w];
    @(negedge clk);
    check(abort == 1'b0, "R12 abort one cycle wide", {31'd0, abort}, 32'd0);
  endtask

  task automatic do_evict(int l, bit exp_abort, string req);
    evict_valid = 1; evict_line = 3'(l);
    @(negedge clk);
    check(abort == exp_abort, req, {31'd0, abort}, {31'd0, exp_abort});
    evict_valid = 0;
    @(negedge clk);
    check(abort == 1'b0, "R12 abort one cycle wide after evict", {31'd0, abort}, 32'd0);
  endtask

  initial begin
    for (int l = 0; l < LINES; l++)
      for (int w = 0; w < WORDS; w++) mem[l][w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(abort == 0, "R1 abort low after reset", {31'd0, abort}, 32'd0);
    check(refill_req == 0, "R1 no refill after reset", {31'd0, refill_req}, 32'd0);
    do_load(4, 9, 0, "R1 reset data zero");

    for (int l = 0; l < LINES; l++) begin
      pulse_begin();
      do_rsp(l, 31, 0, 0, "R6 fill unmarked line");
    end
    for (int l = 0; l < LINES; l++) begin
      for (int w = 0; w < WORDS; w++) rsp_data[w*WB +: WB] = 32'h1000_0000 + l*256 + w;
      for (int w = 0; w < WORDS; w++) mem[l][w] = 32'h1000_0000 + l*256 + w;
      rsp_valid = 1; rsp_line = 3'(l);
      @(negedge clk);
      rsp_valid = 0;
    end
    pulse_commit();

    for (int i = 0; i < 8; i++) begin
      int l, w, c;
      bit e;
      l = int'(VEC[i][12:10]); w = int'(VEC[i][9:6]); c = int'(VEC[i][5:1]); e = VEC[i][0];
      pulse_begin();
      do_load(l, w, 1, "R3 stale load in table");
      do_rsp(l, c, 32'h00A5_5A00 + i, e,
             e ? "R5 marked word changed" : (c == 31 ? "R7 silent rewrite" : "R6 false sharing"));
      do_load(l, (c == 31) ? w : c, 0, "R8 line replaced");
      pulse_commit();
    end

    do_load(2, 4, 1, "R4 load outside txn");
    pulse_begin();
    do_rsp(2, 4, 32'hFFFF_0000, 0, "R4 no mark outside transaction");
    pulse_commit();

    pulse_begin();
    do_load(3, 1, 0, "R5 two marks");
    do_load(3, 6, 1, "R5 two marks");
    do_rsp(3, 6, 32'h0000_0F0F, 1, "R5 second marked word changed");
    do_load(3, 6, 0, "R8 replaced after failed validation");
    do_rsp(3, 1, 32'h1234_0000, 0, "R9 marks gone after conflict");
    pulse_commit();

    pulse_begin();
    do_load(0, 2, 1, "R10 prior txn");
    pulse_commit();
    pulse_begin();
    do_rsp(0, 2, 32'h0F0F_0F0F, 0, "R10 commit cleared marks");
    do_load(5, 7, 1, "R10 prior txn");
    pulse_abort();
    pulse_begin();
    do_rsp(5, 7, 32'h3333_0000, 0, "R10 external abort cleared marks");

    do_load(2, 11, 0, "R11 mark line");
    do_evict(5, 0, "R11 unmarked eviction no abort");
    do_evict(2, 1, "R11 marked eviction aborts");
    pulse_commit();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      runs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule